// File: doc/BRIEF.md
# Microprocessor Bus Cycle Classifier

This block watches the bus of an 8-bit microprocessor on every clock: five active-low control strobes, a 16-bit address bus and an 8-bit data bus. The strobes are machine-cycle-one, read, write, memory request and I/O request. On each sample it decodes the strobes into one of seven cycle types, using a fixed priority. It then follows how that type changes from one sample to the next.

When a bus cycle begins, the block emits a one-clock start pulse. The pulse carries the address seen on that sample and the raw cycle type. When the cycle finishes, it emits a one-clock end pulse. That pulse carries the last data byte seen while the cycle was active and a data tag derived from the cycle type. If the bus jumps straight from one active type to a different active type, the block emits a one-clock illegal-transition pulse and drops the pending address.

The inputs are expected to be synchronised already. Trace tools and bus monitors can use the three pulse streams directly to build records of bus traffic.

Top module: `bus_cycle_classifier`

## Requirements
- R1: Cycle types are coded on 3 bits as NONE=0, MEMRD=1, MEMWR=2, IORD=3, IOWR=4, FETCH=5, INTACK=6. This code appears on `start_type`.
- R2: Memory request low is checked first:
  - read low gives FETCH when machine-cycle-one is low, and MEMRD otherwise;
  - if read is not low, write low gives MEMWR;
  - if neither read nor write is low, the type is NONE, whatever I/O request is.
- R3: With memory request high and I/O request low, the checks run in this order:
  - machine-cycle-one low gives INTACK;
  - otherwise read low gives IORD;
  - otherwise write low gives IOWR.
- R4: Any other strobe combination is NONE. A sample that is NONE after a NONE sample produces no pulse.
- R5: When a sample is active and the previous sample was NONE, `start_pulse` is high for exactly one clock on the next cycle, as follows:
  - `start_addr` holds the address of that sample;
  - `start_type` holds the decoded type;
  - `addr_valid` rises.
- R6: When a sample is NONE and the previous sample was active, `end_pulse` is high for one clock on the next cycle, as follows:
  - `end_data` holds the data byte of the last active sample;
  - `addr_valid` falls.
- R7: `end_type` reports the ending cycle with FETCH mapped to MEMRD (1) and INTACK mapped to IORD (3). The other types are passed through, so `end_type` is always in the range 1 to 4.
- R8: When a sample is active and differs from an active previous sample, `illegal_pulse` is high for one clock and `addr_valid` falls. No start pulse or end pulse is produced for that sample.
- R9: While consecutive samples have the same active type, no pulse is produced and the captured data keeps following the data bus.
- R10: A synchronous active-high reset clears all pulses, `addr_valid`, `start_addr`, `start_type`, `end_data` and `end_type`, and sets the previous type to NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| addr | input | 16 | Address bus |
| data | input | 8 | Data bus |
| start_pulse | output | 1 | One-clock pulse at cycle begin |
| start_addr | output | 16 | Address captured at cycle begin |
| start_type | output | 3 | Raw cycle type at cycle begin |
| addr_valid | output | 1 | Captured address still belongs to the open cycle |
| end_pulse | output | 1 | One-clock pulse at cycle end |
| end_data | output | 8 | Last data byte of the ended cycle |
| end_type | output | 3 | Data tag of the ended cycle |
| illegal_pulse | output | 1 | One-clock pulse on a direct active-to-active change |

## Verification
The bench targets several corner cases, each with the symptom a faulty design would show:
- **Strobe priority clashes.** These include memory request and I/O request low together, and read and write low together. A design with the wrong priority would report MEMWR or INTACK where MEMRD or FETCH belongs.
- **Memory request low with neither read nor write low.** The cycle must stay NONE. A design that falls through to the I/O checks would emit a spurious start.
- **Changing data within a held cycle.** A design that latches data at cycle begin, or on the idle sample, would report the wrong `end_data`.
- **Direct type jumps.** A design that treats a jump as an end plus a begin would pulse `start_pulse` and keep `addr_valid` high.

Long random runs of held strobe patterns mix all of these with the tag mapping of FETCH and INTACK.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [2:0] {
        CYC_NONE   = 3'd0,
        CYC_MEMRD  = 3'd1,
        CYC_MEMWR  = 3'd2,
        CYC_IORD   = 3'd3,
        CYC_IOWR   = 3'd4,
        CYC_FETCH  = 3'd5,
        CYC_INTACK = 3'd6
    } cyc_t;

    // active-low strobe bundle as sampled from the bus
    typedef struct packed {
        logic m1_n;
        logic rd_n;
        logic wr_n;
        logic mreq_n;
        logic iorq_n;
    } strobe_t;

    function automatic cyc_t classify(strobe_t s);
        cyc_t c;
        c = CYC_NONE;
        if (!s.mreq_n) begin
            if (!s.rd_n)      c = s.m1_n ? CYC_MEMRD : CYC_FETCH;
            else if (!s.wr_n) c = CYC_MEMWR;
        end else if (!s.iorq_n) begin
            if (!s.m1_n)      c = CYC_INTACK;
            else if (!s.rd_n) c = CYC_IORD;
            else if (!s.wr_n) c = CYC_IOWR;
        end
        return c;
    endfunction

    function automatic cyc_t data_tag(cyc_t c);
        case (c)
            CYC_FETCH:  return CYC_MEMRD;
            CYC_INTACK: return CYC_IORD;
            default:    return c;
        endcase
    endfunction

endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
    import bcc_pkg::*;
(
    input  strobe_t strobes,
    output cyc_t    cyc
);
    // R2 R3 R4: priority decode of the strobes
    always_comb cyc = classify(strobes);
endmodule

// File: rtl/bcc_tracker.sv
module bcc_tracker
    import bcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cyc_t cur,
    output cyc_t prev,
    output logic begin_ev,
    output logic end_ev,
    output logic bad_ev
);
    always_ff @(posedge clk) begin
        if (rst) prev <= CYC_NONE;
        else     prev <= cur;
    end

    always_comb begin
        begin_ev = (prev == CYC_NONE) && (cur != CYC_NONE);
        end_ev   = (prev != CYC_NONE) && (cur == CYC_NONE);
        bad_ev   = (prev != CYC_NONE) && (cur != CYC_NONE) && (cur != prev);
    end

    // R4: two idle samples in a row never yield an event
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (prev == CYC_NONE && cur == CYC_NONE) |-> !(begin_ev || end_ev || bad_ev));
endmodule

// File: rtl/bcc_capture.sv
module bcc_capture
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_t              cur,
    input  cyc_t              prev,
    input  logic              begin_ev,
    input  logic              end_ev,
    input  logic              bad_ev,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              start_pulse,
    output logic [ADDR_W-1:0] start_addr,
    output cyc_t              start_type,
    output logic              addr_valid,
    output logic              end_pulse,
    output logic [DATA_W-1:0] end_data,
    output cyc_t              end_type,
    output logic              illegal_pulse
);
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q        <= '0;
            start_pulse   <= 1'b0;
            start_addr    <= '0;
            start_type    <= CYC_NONE;
            addr_valid    <= 1'b0;
            end_pulse     <= 1'b0;
            end_data      <= '0;
            end_type      <= CYC_NONE;
            illegal_pulse <= 1'b0;
        end else begin
            start_pulse   <= begin_ev;
            end_pulse     <= end_ev;
            illegal_pulse <= bad_ev;
            if (cur != CYC_NONE) data_q <= data;   // R9 follow data bus
            if (begin_ev) begin                   // R5
                start_addr <= addr;
                start_type <= cur;
                addr_valid <= 1'b1;
            end
            if (end_ev || bad_ev) addr_valid <= 1'b0;  // R6 R8
            if (end_ev) begin                     // R6 R7
                end_data <= data_q;
                end_type <= data_tag(prev);
            end
        end
    end

    assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);
    assert_start_valid_R5: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> addr_valid);
    assert_end_single_R6: assert property (@(posedge clk) disable iff (rst)
        end_pulse |=> !end_pulse);
    assert_tag_range_R7: assert property (@(posedge clk) disable iff (rst)
        end_pulse |-> (end_type >= CYC_MEMRD && end_type <= CYC_IOWR));
    assert_illegal_excl_R8: assert property (@(posedge clk) disable iff (rst)
        illegal_pulse |-> !(start_pulse || end_pulse || addr_valid));
    assert_pulses_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_pulse, end_pulse, illegal_pulse}));
endmodule

// File: rtl/bus_cycle_classifier.sv
module bus_cycle_classifier
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m1_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              start_pulse,
    output logic [ADDR_W-1:0] start_addr,
    output logic [2:0]        start_type,
    output logic              addr_valid,
    output logic              end_pulse,
    output logic [DATA_W-1:0] end_data,
    output logic [2:0]        end_type,
    output logic              illegal_pulse
);
    strobe_t strobes;
    cyc_t    cur, prev, s_type, e_type;
    logic    begin_ev, end_ev, bad_ev;

    assign strobes = '{m1_n: m1_n, rd_n: rd_n, wr_n: wr_n, mreq_n: mreq_n, iorq_n: iorq_n};

    bcc_decode u_decode (.strobes(strobes), .cyc(cur));

    bcc_tracker u_tracker (
        .clk(clk), .rst(rst), .cur(cur), .prev(prev),
        .begin_ev(begin_ev), .end_ev(end_ev), .bad_ev(bad_ev)
    );

    bcc_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk(clk), .rst(rst), .cur(cur), .prev(prev),
        .begin_ev(begin_ev), .end_ev(end_ev), .bad_ev(bad_ev),
        .addr(addr), .data(data),
        .start_pulse(start_pulse), .start_addr(start_addr), .start_type(s_type),
        .addr_valid(addr_valid), .end_pulse(end_pulse), .end_data(end_data),
        .end_type(e_type), .illegal_pulse(illegal_pulse)
    );

    assign start_type = s_type;
    assign end_type   = e_type;

    // R2: memory request with read low never reports an I/O type
    assert_mem_first_R2: assert property (@(posedge clk) disable iff (rst)
        (!mreq_n && !rd_n && prev == CYC_NONE) |=>
            (start_pulse && (start_type == CYC_MEMRD || start_type == CYC_FETCH)));
endmodule

// File: tb/tb_bus_cycle_classifier.sv
`timescale 1ns/1ps
module tb_bus_cycle_classifier;
    logic        clk = 1'b0;
    logic        rst;
    logic        m1_n, rd_n, wr_n, mreq_n, iorq_n;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        start_pulse, addr_valid, end_pulse, illegal_pulse;
    logic [15:0] start_addr;
    logic [2:0]  start_type, end_type;
    logic [7:0]  end_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state
    logic [2:0]  m_prev;
    logic [7:0]  m_dq;
    logic        e_start, e_end, e_ill, e_valid;
    logic [15:0] e_saddr;
    logic [2:0]  e_stype, e_etype;
    logic [7:0]  e_edata;

    always #2 clk = ~clk;

    bus_cycle_classifier dut (
        .clk(clk), .rst(rst), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .addr(addr), .data(data),
        .start_pulse(start_pulse), .start_addr(start_addr), .start_type(start_type),
        .addr_valid(addr_valid), .end_pulse(end_pulse), .end_data(end_data),
        .end_type(end_type), .illegal_pulse(illegal_pulse)
    );

    function automatic logic [2:0] ref_type(logic m1, logic rd, logic wr, logic mq, logic io);
        if (!mq) begin
            if (!rd) return m1 ? 3'd1 : 3'd5;
            if (!wr) return 3'd2;
            return 3'd0;
        end
        if (!io) begin
            if (!m1) return 3'd6;
            if (!rd) return 3'd3;
            if (!wr) return 3'd4;
        end
        return 3'd0;
    endfunction

    function automatic logic [2:0] ref_tag(logic [2:0] t);
        if (t == 3'd5) return 3'd1;
        if (t == 3'd6) return 3'd3;
        return t;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(logic m1, logic rd, logic wr, logic mq, logic io,
                        logic [15:0] a, logic [7:0] d);
        logic [2:0] c;
        @(negedge clk);
        m1_n = m1; rd_n = rd; wr_n = wr; mreq_n = mq; iorq_n = io;
        addr = a; data = d;
        c = ref_type(m1, rd, wr, mq, io);
        e_start = (m_prev == 3'd0) && (c != 3'd0);
        e_end   = (m_prev != 3'd0) && (c == 3'd0);
        e_ill   = (m_prev != 3'd0) && (c != 3'd0) && (c != m_prev);
        if (e_start) begin e_saddr = a; e_stype = c; e_valid = 1'b1; end
        if (e_end || e_ill) e_valid = 1'b0;
        if (e_end) begin e_edata = m_dq; e_etype = ref_tag(m_prev); end
        if (c != 3'd0) m_dq = d;
        m_prev = c;
        @(posedge clk);
        #1;
        chk("R5 start_pulse", start_pulse, e_start);
        chk("R6 end_pulse", end_pulse, e_end);
        chk("R8 illegal_pulse", illegal_pulse, e_ill);
        chk("R8 addr_valid", addr_valid, e_valid);
        if (e_start) begin
            chk("R5 start_addr", start_addr, e_saddr);
            chk("R1 R2 R3 start_type", start_type, e_stype);
        end
        if (e_end) begin
            chk("R6 R9 end_data", end_data, e_edata);
            chk("R7 end_type", end_type, e_etype);
        end
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        rst = 1'b1;
        m1_n = 1; rd_n = 1; wr_n = 1; mreq_n = 1; iorq_n = 1; addr = 0; data = 0;
        m_prev = 0; m_dq = 0; e_valid = 0; e_saddr = 0; e_stype = 0; e_etype = 0; e_edata = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 start_pulse", start_pulse, 0);
        chk("R10 end_pulse", end_pulse, 0);
        chk("R10 illegal_pulse", illegal_pulse, 0);
        chk("R10 addr_valid", addr_valid, 0);
        chk("R10 start_addr", start_addr, 0);
        chk("R10 end_type", end_type, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2 fetch held with changing data (R9), end tag MEMRD (R7)
        step(0,0,1,0,1, 16'h1234, 8'h3E);
        step(0,0,1,0,1, 16'h1235, 8'h11);
        step(0,0,1,0,1, 16'h1236, 8'h77);
        step(1,1,1,1,1, 16'h0000, 8'hAA);
        // R2 read and write both low: read wins
        step(1,0,0,0,1, 16'h4000, 8'h21);
        step(1,1,1,1,1, 16'h0000, 8'h00);
        // R2 memory request beats I/O request: MEMWR
        step(1,1,0,0,0, 16'h5000, 8'h42);
        step(1,1,1,1,1, 16'h0000, 8'h00);
        // R4 memory request low, no read/write, I/O and m1 low: stays NONE
        step(0,1,1,0,0, 16'h6000, 8'h55);
        step(0,1,1,0,0, 16'h6001, 8'h56);
        step(1,1,1,1,1, 16'h0000, 8'h00);
        // R3 interrupt acknowledge beats read, tagged IORD
        step(0,0,1,1,0, 16'h00FF, 8'hC7);
        step(1,1,1,1,1, 16'h0000, 8'h00);
        // R3 IORD then IOWR
        step(1,0,1,1,0, 16'h0010, 8'h01);
        step(1,1,1,1,1, 16'h0000, 8'h00);
        step(1,1,0,1,0, 16'h0020, 8'h02);
        step(1,1,1,1,1, 16'h0000, 8'h00);
        // R8 direct MEMRD to IOWR jump, then idle
        step(1,0,1,0,1, 16'h7000, 8'h10);
        step(1,1,0,1,0, 16'h7001, 8'h20);
        step(1,1,1,1,1, 16'h0000, 8'h00);

        // random held patterns
        for (int seg = 0; seg < 3000; seg++) begin
            logic [4:0] s;
            int hold;
            s = ($urandom % 5 < 2) ? 5'b11111 : 5'($urandom);
            hold = 1 + ($urandom % 4);
            for (int k = 0; k < hold; k++)
                step(s[4], s[3], s[2], s[1], s[0], 16'($urandom), 8'($urandom));
        end
        step(1,1,1,1,1, 16'h0000, 8'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule